// File: doc/BRIEF.md
# I2C Target Interface with Four Programmable Addresses

This block is the target (slave) side of an I2C bus. It samples the bus clock and data lines through a short synchroniser, detects start, repeated start and stop conditions, and compares the first byte of every transfer against four address slots. Each slot holds either a 7-bit address or a 10-bit address. When a slot matches, the block pulls the data line low during the acknowledge clock and then takes part in the transfer.

In a write transfer, each received byte goes into a two-entry receive queue that the host logic drains. In a read transfer, bytes are sent most significant bit first from a two-entry transmit queue that the host logic fills. If a queue cannot keep up, the block holds the clock line low until the host logic catches up. A host input can turn the acknowledge of a received data byte into a not-acknowledge, for example to reject a bad checksum.

Both bus lines are open-drain. The block only ever asks for a line to be pulled low, and the pad logic outside it builds the wired-AND bus.

Top module: `i2c_quad_target`

## Requirements
- R1: A first byte whose upper seven bits equal a 7-bit slot's address `[6:0]` is acknowledged: SDA is pulled low for the ninth clock, `match_o` goes high, `match_idx_o` gives the slot and `read_o` copies bit 0 of the byte (1 = read).
- R2: When several slots match the same byte, the slot with the lowest index is reported.
- R3: A 10-bit slot matches a first byte of the form `11110`, address bits `[9:8]`, 0, followed by a second byte equal to address bits `[7:0]`. Both bytes are acknowledged. If the second byte differs, it is not acknowledged and `match_o` stays low.
- R4: After a 10-bit write match, a repeated start followed by `11110`, address bits `[9:8]`, 1 is acknowledged as a read for that same slot, and transmission starts.
- R5: A first byte that matches no slot is not acknowledged. SDA is then never pulled low and no byte is stored until the next start condition.
- R6: A repeated start restarts address matching without a stop in between. A stop clears `match_o` and gives a one-cycle pulse on `stop_o`.
- R7: Changes to `addr_cfg_i` or `addr_ten_i` made between a start and the following stop have no effect until that stop.
- R8: Received data bytes enter a two-entry receive queue in order. `rx_data_o` shows the oldest entry and `rx_level_o` gives the fill count. A pop while the queue is empty is ignored.
- R9: When a data byte completes while the receive queue is full, SCL is held low until an entry is popped. The byte is then stored and acknowledged.
- R10: While `nack_i` is high at the acknowledge point of a data byte, SDA is left released (not-acknowledge), and the byte is still stored.
- R11: A read sends queued bytes MSB first. SCL is held low while the transmit queue is empty at a byte start. A push to a full transmit queue is ignored. A not-acknowledge from the master ends the sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| scl_oe_o | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| addr_cfg_i | input | NADDR*10 | Slot addresses, slot k at bits [10k+9:10k] |
| addr_ten_i | input | NADDR | Per slot: 1 = 10-bit address, 0 = 7-bit address in bits [6:0] |
| nack_i | input | 1 | 1 = not-acknowledge received data bytes |
| rx_data_o | output | 8 | Oldest received byte |
| rx_pop_i | input | 1 | Remove the oldest received byte |
| rx_level_o | output | clog2(FIFO_DEPTH+1) | Receive queue fill count |
| tx_data_i | input | 8 | Byte to queue for sending |
| tx_push_i | input | 1 | Queue `tx_data_i` |
| tx_level_o | output | clog2(FIFO_DEPTH+1) | Transmit queue fill count |
| match_o | output | 1 | Addressed in the current transfer |
| match_idx_o | output | clog2(NADDR) | Index of the matched slot |
| read_o | output | 1 | Current transfer direction, 1 = read |
| stop_o | output | 1 | One-cycle pulse on a stop condition |

## Verification
The bench builds the block with its default parameters: four address slots, two-entry queues and a two-stage synchroniser. With two-entry queues, a full receive queue is reached on the third byte of a single write, and an empty transmit queue is reached at the first data byte of a read, so both stretch paths occur in short transfers. Two slots are set to 7-bit and two to 10-bit, so both address forms, the 10-bit read after a repeated start, and the lowest-index rule (by giving two slots the same address) can be exercised in the same configuration.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECV,
        S_ACK,
        S_SEND,
        S_MACK,
        S_HOLD
    } state_e;

    typedef enum logic [1:0] {
        PH_ADDR1,
        PH_ADDR2,
        PH_DATA
    } phase_e;

    localparam logic [4:0] TEN_PREFIX = 5'b11110;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2ct_fifo.sv
module i2ct_fifo #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 2,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pop_i,
    output logic [DW-1:0] rdata_o,
    output logic [LW-1:0] level_o
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wptr;
        logic [AW-1:0]            rptr;
        logic [LW-1:0]            cnt;
    } fifo_t;

    fifo_t r_q, r_d;
    logic  full, empty, do_push, do_pop;

    assign full    = (r_q.cnt == LW'(DEPTH));
    assign empty   = (r_q.cnt == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty;

    always_comb begin
        r_d = r_q;
        if (do_push) begin
            r_d.mem[r_q.wptr] = wdata_i;
            r_d.wptr = (r_q.wptr == AW'(DEPTH - 1)) ? '0 : r_q.wptr + AW'(1);
        end
        if (do_pop) begin
            r_d.rptr = (r_q.rptr == AW'(DEPTH - 1)) ? '0 : r_q.rptr + AW'(1);
        end
        r_d.cnt = r_q.cnt + LW'(do_push) - LW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o = r_q.mem[r_q.rptr];
    assign level_o = r_q.cnt;

    // R8 / R11: a push into a full queue leaves the level alone
    p_full_push_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == LW'(DEPTH) && push_i && !pop_i) |=> $stable(level_o));

    // R8: a pop from an empty queue leaves it empty
    p_empty_pop_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0 && pop_i && !push_i) |=> (level_o == '0));
endmodule

// File: rtl/i2ct_match.sv
module i2ct_match
    import i2ct_pkg::*;
#(
    parameter int unsigned NADDR = 4,
    localparam int unsigned IW   = $clog2(NADDR)
) (
    input  logic [7:0]          rx_byte_i,
    input  logic                second_i,
    input  logic [NADDR-1:0]    cand_i,
    input  logic                ten_ok_i,
    input  logic [IW-1:0]       ten_idx_i,
    input  logic [NADDR*10-1:0] acfg_i,
    input  logic [NADDR-1:0]    aten_i,
    output logic                hit_o,
    output logic [IW-1:0]       idx_o,
    output logic [NADDR-1:0]    pre_o
);
    logic [NADDR-1:0] full;

    for (genvar gi = 0; gi < NADDR; gi++) begin : g_slot
        logic [9:0] a;
        logic       prefix_ok;
        assign a         = acfg_i[gi*10 +: 10];
        assign prefix_ok = aten_i[gi] && (rx_byte_i[7:3] == TEN_PREFIX)
                           && (rx_byte_i[2:1] == a[9:8]);
        assign full[gi]  = second_i
            ? (cand_i[gi] && (rx_byte_i == a[7:0]))
            : ((!aten_i[gi] && (rx_byte_i[7:1] == a[6:0]))
               || (prefix_ok && rx_byte_i[0] && ten_ok_i && (ten_idx_i == IW'(gi))));
        assign pre_o[gi] = !second_i && prefix_ok && !rx_byte_i[0];
    end

    // R2: lowest matching index wins
    always_comb begin
        idx_o = '0;
        for (int i = NADDR - 1; i >= 0; i--) begin
            if (full[i]) idx_o = IW'(i);
        end
    end

    assign hit_o = |full;
endmodule

// File: rtl/i2c_quad_target.sv
module i2c_quad_target
    import i2ct_pkg::*;
#(
    parameter int unsigned NADDR       = 4,
    parameter int unsigned FIFO_DEPTH  = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             scl_i,
    input  logic                             sda_i,
    output logic                             scl_oe_o,
    output logic                             sda_oe_o,
    input  logic [NADDR*10-1:0]              addr_cfg_i,
    input  logic [NADDR-1:0]                 addr_ten_i,
    input  logic                             nack_i,
    output logic [7:0]                       rx_data_o,
    input  logic                             rx_pop_i,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]  rx_level_o,
    input  logic [7:0]                       tx_data_i,
    input  logic                             tx_push_i,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]  tx_level_o,
    output logic                             match_o,
    output logic [$clog2(NADDR)-1:0]         match_idx_o,
    output logic                             read_o,
    output logic                             stop_o
);
    localparam int unsigned IW  = $clog2(NADDR);
    localparam int unsigned LVW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        state_e               st;
        phase_e               ph;
        logic [3:0]           cnt;
        logic [7:0]           sh;
        logic                 sda_oe;
        logic                 scl_oe;
        logic                 next_send;
        logic                 hold_tx;
        logic                 busy;
        logic                 match;
        logic [IW-1:0]        idx;
        logic                 rd;
        logic                 stop;
        logic                 ten_ok;
        logic [NADDR-1:0]     cand;
        logic [NADDR*10-1:0]  acfg;
        logic [NADDR-1:0]     aten;
        logic                 scl_p;
        logic                 sda_p;
    } regs_t;

    regs_t r, n;
    logic  scl_s, sda_s;
    logic  scl_rise, scl_fall, start_det, stop_det;
    logic  rx_push, tx_pop, rx_full, tx_empty;
    logic  m_hit;
    logic [IW-1:0]    m_idx;
    logic [NADDR-1:0] m_pre;
    logic [7:0]       tx_head;

    i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
    );

    i2ct_match #(.NADDR(NADDR)) u_match (
        .rx_byte_i(r.sh), .second_i(r.ph == PH_ADDR2), .cand_i(r.cand),
        .ten_ok_i(r.ten_ok), .ten_idx_i(r.idx), .acfg_i(r.acfg), .aten_i(r.aten),
        .hit_o(m_hit), .idx_o(m_idx), .pre_o(m_pre)
    );

    i2ct_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .wdata_i(r.sh),
        .pop_i(rx_pop_i), .rdata_o(rx_data_o), .level_o(rx_level_o)
    );

    i2ct_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push_i), .wdata_i(tx_data_i),
        .pop_i(tx_pop), .rdata_o(tx_head), .level_o(tx_level_o)
    );

    assign scl_rise  = scl_s && !r.scl_p;
    assign scl_fall  = !scl_s && r.scl_p;
    assign start_det = scl_s && r.scl_p && r.sda_p && !sda_s;
    assign stop_det  = scl_s && r.scl_p && !r.sda_p && sda_s;
    assign rx_full   = (rx_level_o == LVW'(FIFO_DEPTH));
    assign tx_empty  = (tx_level_o == '0);

    // start a transmit byte, or stretch until the queue has one
    function automatic regs_t begin_tx(regs_t x, logic empty, logic [7:0] d);
        if (empty) begin
            x.st = S_HOLD; x.hold_tx = 1'b1; x.scl_oe = 1'b1; x.sda_oe = 1'b0;
        end else begin
            x.st = S_SEND; x.sh = d; x.sda_oe = !d[7]; x.cnt = '0; x.scl_oe = 1'b0;
        end
        return x;
    endfunction

    always_comb begin
        n = r;
        n.stop  = 1'b0;
        n.scl_p = scl_s;
        n.sda_p = sda_s;
        if (!r.busy) begin
            n.acfg = addr_cfg_i;
            n.aten = addr_ten_i;
        end
        if (stop_det) begin
            n.st = S_IDLE; n.busy = 1'b0; n.match = 1'b0; n.ten_ok = 1'b0;
            n.sda_oe = 1'b0; n.scl_oe = 1'b0; n.stop = 1'b1;
        end else if (start_det) begin
            n.st = S_RECV; n.ph = PH_ADDR1; n.cnt = '0; n.busy = 1'b1;
            n.match = 1'b0; n.sda_oe = 1'b0; n.scl_oe = 1'b0;
        end else begin
            unique case (r.st)
                S_RECV: begin
                    if (scl_rise && r.cnt < 4'd8) begin
                        n.sh  = {r.sh[6:0], sda_s};
                        n.cnt = r.cnt + 4'd1;
                    end else if (scl_fall && r.cnt == 4'd8) begin
                        unique case (r.ph)
                            PH_ADDR1: begin
                                if (m_hit) begin
                                    n.match = 1'b1; n.idx = m_idx; n.rd = r.sh[0];
                                    n.next_send = r.sh[0]; n.ph = PH_DATA;
                                    n.st = S_ACK; n.sda_oe = 1'b1;
                                end else if (|m_pre) begin
                                    n.cand = m_pre; n.ph = PH_ADDR2; n.next_send = 1'b0;
                                    n.st = S_ACK; n.sda_oe = 1'b1;
                                end else begin
                                    n.st = S_IDLE;
                                end
                            end
                            PH_ADDR2: begin
                                if (m_hit) begin
                                    n.match = 1'b1; n.idx = m_idx; n.rd = 1'b0;
                                    n.ten_ok = 1'b1; n.ph = PH_DATA; n.next_send = 1'b0;
                                    n.st = S_ACK; n.sda_oe = 1'b1;
                                end else begin
                                    n.st = S_IDLE;
                                end
                            end
                            default: begin
                                if (rx_full) begin
                                    n.st = S_HOLD; n.hold_tx = 1'b0; n.scl_oe = 1'b1;
                                end else begin
                                    n.st = S_ACK; n.sda_oe = !nack_i;
                                end
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        n.sda_oe = 1'b0;
                        if (r.next_send) begin
                            n = begin_tx(n, tx_empty, tx_head);
                        end else begin
                            n.st = S_RECV; n.cnt = '0;
                        end
                    end
                end
                S_HOLD: begin
                    if (r.hold_tx) begin
                        if (!tx_empty) n = begin_tx(n, 1'b0, tx_head);
                    end else if (!rx_full) begin
                        n.st = S_ACK; n.sda_oe = !nack_i; n.scl_oe = 1'b0;
                    end
                end
                S_SEND: begin
                    if (scl_rise) begin
                        n.cnt = r.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (r.cnt == 4'd8) begin
                            n.sda_oe = 1'b0; n.st = S_MACK;
                        end else begin
                            n.sh = {r.sh[6:0], 1'b0}; n.sda_oe = !r.sh[6];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        n.next_send = !sda_s;
                    end else if (scl_fall) begin
                        if (r.next_send) n = begin_tx(n, tx_empty, tx_head);
                        else             n.st = S_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign tx_pop  = (n.st == S_SEND) && (r.st != S_SEND);
    assign rx_push = (n.st == S_ACK) && (r.st != S_ACK) && (r.ph == PH_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r       <= '0;
            r.st    <= S_IDLE;
            r.ph    <= PH_ADDR1;
            r.scl_p <= 1'b1;
            r.sda_p <= 1'b1;
        end else begin
            r <= n;
        end
    end

    assign scl_oe_o    = r.scl_oe;
    assign sda_oe_o    = r.sda_oe;
    assign match_o     = r.match;
    assign match_idx_o = r.idx;
    assign read_o      = r.rd;
    assign stop_o      = r.stop;

    // R1: SDA is only taken low in a cycle that follows a low SCL
    p_sda_low_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !$past(scl_s));

    // R9 / R11: stretching starts only on a full receive or empty transmit queue
    p_stretch_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe_o) |-> ($past(rx_level_o) == LVW'(FIFO_DEPTH) || $past(tx_level_o) == '0));

    // R6: a stop leaves the block unaddressed with both lines released
    p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (!match_o && !sda_oe_o && !scl_oe_o));

    // R7: the address shadow is frozen while a transfer is open
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r.busy) |-> ($stable(r.acfg) && $stable(r.aten)));
endmodule

// File: tb/sim_i2c_quad_target.sv
`timescale 1ns/100ps
module sim_i2c_quad_target;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        scl_oe, sda_oe;
    logic [39:0] cfg;
    logic [3:0]  ten;
    logic        nack = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_pop = 1'b0;
    logic [1:0]  rx_level, tx_level;
    logic [7:0]  tx_data = '0;
    logic        tx_push = 1'b0;
    logic        match, read_dir, stop_p;
    logic [1:0]  midx;

    wire scl_line = scl_m & ~scl_oe;
    wire sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_quad_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .addr_cfg_i(cfg), .addr_ten_i(ten),
        .nack_i(nack), .rx_data_o(rx_data), .rx_pop_i(rx_pop), .rx_level_o(rx_level),
        .tx_data_i(tx_data), .tx_push_i(tx_push), .tx_level_o(tx_level),
        .match_o(match), .match_idx_o(midx), .read_o(read_dir), .stop_o(stop_p)
    );

    int checks = 0, fails = 0;
    int stops = 0;
    bit sda_seen = 0;
    int stretch_cnt = 0, max_stretch = 0;
    int relief_mode = 0;
    logic [7:0] relief_byte = '0;
    logic [7:0] relief_pop = '0;
    bit done = 0;

    always @(posedge clk) begin
        if (rst_n && stop_p) stops++;
        if (rst_n && sda_oe) sda_seen = 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic set_slot(input int i, input logic [9:0] a, input logic t);
        cfg[i*10 +: 10] = a;
        ten[i] = t;
    endtask

    function automatic int exp_idx(input logic [6:0] a);
        for (int i = 3; i >= 0; i--) begin
            if (!ten[i] && cfg[i*10 +: 7] == a) return i;
        end
        return -1;
    endfunction

    task automatic relieve();
        if (relief_mode == 1) begin
            relief_pop = rx_data;
            rx_pop = 1'b1; hw(1); rx_pop = 1'b0;
        end else if (relief_mode == 2) begin
            tx_data = relief_byte;
            tx_push = 1'b1; hw(1); tx_push = 1'b0;
        end
        relief_mode = 0;
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; hw(HALF);
        scl_m = 1'b1; hw(1);
        stretch_cnt = 0;
        while (!scl_line && stretch_cnt < 5000) begin
            stretch_cnt++;
            if (stretch_cnt == 20) relieve();
            hw(1);
        end
        if (stretch_cnt > max_stretch) max_stretch = stretch_cnt;
        hw(HALF/2); r = sda_line; hw(HALF/2);
        scl_m = 1'b0; hw(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hw(HALF);
        sda_m = 1'b0; hw(HALF);
        scl_m = 1'b0; hw(HALF);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hw(HALF);
        scl_m = 1'b1; hw(HALF);
        sda_m = 1'b0; hw(HALF);
        scl_m = 1'b0; hw(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(HALF);
        scl_m = 1'b1; hw(HALF);
        sda_m = 1'b1; hw(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
        clk_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic mack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            d[i] = r;
        end
        clk_bit(!mack, r);
    endtask

    task automatic pop_rx(output logic [7:0] d);
        d = rx_data;
        rx_pop = 1'b1; hw(1); rx_pop = 1'b0; hw(1);
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_data = d;
        tx_push = 1'b1; hw(1); tx_push = 1'b0; hw(1);
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        int         st0;
        int unsigned seed;
        seed = $urandom(32'd1357);
        cfg = '0; ten = '0;
        set_slot(0, 10'h02A, 1'b0);
        set_slot(1, 10'h051, 1'b0);
        set_slot(2, 10'h2C5, 1'b1);
        set_slot(3, 10'h1F3, 1'b1);
        hw(5); rst_n = 1'b1; hw(5);

        // reset state
        check(!scl_oe && !sda_oe && !match && !stop_p, "reset outputs idle", {scl_oe, sda_oe, match}, 0);
        check(rx_level == 0 && tx_level == 0, "reset queues empty", {rx_level, tx_level}, 0);

        // R1: 7-bit write to slot 1, then R6 stop
        st0 = stops;
        bus_start(); wr_byte({7'h51, 1'b0}, ack);
        check(ack, "R1 address ack", ack, 1);
        check(match && midx == 1 && !read_dir, "R1 match status", {match, midx, read_dir}, 'b1010);
        wr_byte(8'hA5, ack);
        check(ack && rx_level == 1, "R8 byte stored", rx_level, 1);
        bus_stop(); hw(4);
        check(stops == st0 + 1 && !match, "R6 stop pulse clears match", stops - st0, 1);
        pop_rx(d);
        check(d == 8'hA5, "R8 data value", d, 8'hA5);

        // R2: two slots share an address
        set_slot(1, 10'h02A, 1'b0);
        bus_start(); wr_byte({7'h2A, 1'b0}, ack);
        check(ack && midx == 0, "R2 lowest index wins", midx, 0);
        bus_stop();
        set_slot(1, 10'h051, 1'b0);

        // R3: 10-bit write to slot 2, good and bad second byte
        bus_start(); wr_byte(8'hF4, ack);
        check(ack && !match, "R3 prefix ack", {ack, match}, 'b10);
        wr_byte(8'hC5, ack);
        check(ack && match && midx == 2, "R3 10-bit match", midx, 2);
        wr_byte(8'h3C, ack);
        pop_rx(d);
        check(ack && d == 8'h3C, "R3 data after 10-bit address", d, 8'h3C);

        // R4: repeated start read of the same 10-bit slot
        push_tx(8'h96); push_tx(8'h0F);
        bus_rstart(); wr_byte(8'hF5, ack);
        check(ack && match && read_dir && midx == 2, "R4 10-bit read ack", {ack, read_dir, midx}, 'b1110);
        rd_byte(d, 1'b1);
        check(d == 8'h96, "R4 first read byte", d, 8'h96);
        rd_byte(d, 1'b0);
        check(d == 8'h0F, "R4 second read byte", d, 8'h0F);
        bus_stop();

        bus_start(); wr_byte(8'hF2, ack); wr_byte(8'hF4, ack);
        check(!ack && !match, "R3 wrong low byte refused", {ack, match}, 0);
        bus_stop();

        // R5: unmatched address
        hw(4); sda_seen = 0;
        bus_start(); wr_byte({7'h33, 1'b0}, ack);
        check(!ack, "R5 no ack", ack, 0);
        wr_byte(8'h55, ack);
        check(!sda_seen && rx_level == 0 && !match, "R5 nothing driven or stored", {sda_seen, rx_level}, 0);
        bus_stop();

        // R6: repeated start re-addresses
        bus_start(); wr_byte({7'h2A, 1'b0}, ack);
        wr_byte(8'h11, ack);
        st0 = stops;
        bus_rstart(); wr_byte({7'h51, 1'b0}, ack);
        check(ack && match && midx == 1 && stops == st0, "R6 repeated start rematch", midx, 1);
        bus_stop();
        pop_rx(d);

        // R7: configuration frozen during a transfer
        bus_start(); wr_byte({7'h2A, 1'b0}, ack);
        set_slot(0, 10'h02B, 1'b0);
        bus_rstart(); wr_byte({7'h2B, 1'b0}, ack);
        check(!ack, "R7 new address not yet active", ack, 0);
        bus_rstart(); wr_byte({7'h2A, 1'b0}, ack);
        check(ack, "R7 old address still active", ack, 1);
        bus_stop();
        bus_start(); wr_byte({7'h2B, 1'b0}, ack);
        check(ack, "R7 new address after stop", ack, 1);
        bus_stop();
        set_slot(0, 10'h02A, 1'b0);

        // R8: pop on empty ignored
        rx_pop = 1'b1; hw(1); rx_pop = 1'b0; hw(1);
        check(rx_level == 0, "R8 empty pop ignored", rx_level, 0);

        // R9: third byte stretches until a pop
        bus_start(); wr_byte({7'h51, 1'b0}, ack);
        wr_byte(8'hC1, ack); wr_byte(8'hC2, ack);
        relief_mode = 1; max_stretch = 0;
        wr_byte(8'hC3, ack);
        check(ack && max_stretch >= 20, "R9 stretch on full rx", max_stretch, 20);
        check(relief_pop == 8'hC1, "R9 first byte popped", relief_pop, 8'hC1);
        bus_stop();
        pop_rx(d);
        check(d == 8'hC2, "R9 order kept", d, 8'hC2);
        pop_rx(d);
        check(d == 8'hC3, "R9 held byte stored", d, 8'hC3);

        // R10: software NACK
        bus_start(); wr_byte({7'h2A, 1'b0}, ack);
        nack = 1'b1;
        wr_byte(8'h7E, ack);
        nack = 1'b0;
        check(!ack && rx_level == 1, "R10 nack but stored", {ack, rx_level}, 'b001);
        bus_stop();
        pop_rx(d);
        check(d == 8'h7E, "R10 nacked byte value", d, 8'h7E);

        // R11: read with empty queue stretches; full push ignored
        bus_start(); wr_byte({7'h51, 1'b1}, ack);
        check(ack && read_dir, "R11 read address", {ack, read_dir}, 'b11);
        relief_mode = 2; relief_byte = 8'hB4; max_stretch = 0;
        rd_byte(d, 1'b0);
        check(d == 8'hB4 && max_stretch >= 20, "R11 stretch on empty tx", d, 8'hB4);
        bus_stop();
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
        check(tx_level == 2, "R11 full push ignored", tx_level, 2);
        bus_start(); wr_byte({7'h51, 1'b1}, ack);
        rd_byte(d, 1'b1);
        check(d == 8'h11, "R11 first queued byte", d, 8'h11);
        rd_byte(d, 1'b0);
        check(d == 8'h22 && tx_level == 0, "R11 second byte and nack end", d, 8'h22);
        bus_stop();

        // random mix, R1 / R5 / R8 / R11
        for (int it = 0; it < 24; it++) begin
            logic [6:0] a;
            int e, nb, kind;
            logic [7:0] bytes [2];
            kind = $urandom_range(0, 2);
            a = (kind == 0) ? 7'h2A : (kind == 1) ? 7'h51 : 7'($urandom_range(0, 'h77));
            e = exp_idx(a);
            nb = $urandom_range(1, 2);
            for (int k = 0; k < 2; k++) bytes[k] = 8'($urandom);
            if (e >= 0 && $urandom_range(0, 1) == 1) begin
                for (int k = 0; k < nb; k++) push_tx(bytes[k]);
                bus_start(); wr_byte({a, 1'b1}, ack);
                check(ack && midx == e, "R1 random read address", midx, e);
                for (int k = 0; k < nb; k++) begin
                    rd_byte(d, k != nb - 1);
                    check(d == bytes[k], "R11 random read data", d, bytes[k]);
                end
                bus_stop();
            end else begin
                bus_start(); wr_byte({a, 1'b0}, ack);
                check(ack == (e >= 0), "R5 random address ack", ack, e >= 0);
                for (int k = 0; k < nb; k++) wr_byte(bytes[k], ack);
                bus_stop();
                check(rx_level == ((e >= 0) ? nb : 0), "R8 random level", rx_level, (e >= 0) ? nb : 0);
                if (e >= 0) begin
                    for (int k = 0; k < nb; k++) begin
                        pop_rx(d);
                        check(d == bytes[k], "R8 random data", d, bytes[k]);
                    end
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule